// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. A sixteen-state controller advances on every rising edge of the test clock, steered by the mode-select input. The controller sends the serial stream either through a five-bit instruction register or through one of the data registers. The instruction register has two parts: a shift stage, and a parallel stage that holds the current instruction. The data registers are a one-bit bypass stage, a 32-bit identification register and a 32-bit user-code register. Four more opcodes are decoded for a neighbouring extension block. That block watches the select lines and the controller state and returns its own serial bit on `ext_tdo`.

The instruction register captures a fixed pattern and shifts least significant bit first. Its parallel stage is written on the falling clock edge as the controller enters the instruction-update state. Test-logic-reset loads the identification instruction into the parallel stage. Serial output changes only on falling edges, and its enable is high only while an instruction or data shift is in progress. The identification and user-code values are parameters.

Opcodes: 5'b00010 identification, 5'b00011 user code, 5'b11111 bypass, 5'b01000 to 5'b01011 extension 0 to 3. Every other opcode acts as bypass.

Controller state codes on `tap_state`: reset F, idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8, update-IR D.

Top module: `tap_port`

## Requirements
- R1: Asserting `trst_n` low puts the controller in reset (code F) at once. In that state `tdo_en` is 0 and `inst_sel` selects identification (bit 1).
- R2: From any state, five rising edges with `tms` high reach reset (F), and the identification instruction is forced into the parallel stage.
- R3: In capture-IR the instruction shift stage loads 5'b00001, which then leaves on `tdo` LSB first.
- R4: The instruction is shifted LSB first. It is copied to the parallel stage on the falling edge as update-IR (D) is entered, and `inst_sel` does not change during shift-IR.
- R5: The IR column follows these transitions: exit1-IR goes to pause-IR on tms 0 and to update-IR on tms 1. Pause-IR stays on 0 and goes to exit2-IR on 1. Exit2-IR goes to shift-IR on 0 and to update-IR on 1. Update-IR goes to idle on 0 and to select-DR on 1. Shifting resumes after a pause with no bits lost.
- R6: Under identification, capture-DR loads the ID parameter, whose bit 0 is 1, and shift-DR sends it out LSB first.
- R7: Under user code, capture-DR loads the user-code parameter, which is then shifted out LSB first.
- R8: Under bypass, capture loads 0 and `tdi` reaches `tdo` one shift later.
- R9: Any opcode that is not decoded behaves as bypass and selects `inst_sel` bit 0.
- R10: Extension opcodes 01000, 01001, 01010 and 01011 select `inst_sel` bits 3, 4, 5 and 6. During shift-DR, `tdo` follows `ext_tdo`.
- R11: `tdo` changes only on falling edges of `tck`. `tdo_en` is 1 only after a falling edge in shift-IR or shift-DR.
- R12: `inst_sel` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | 1 | Serial bit returned by the extension block |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for tdo |
| inst_sel | output | 7 | One-hot decode of the current instruction |
| tap_state | output | 4 | Current controller state code |

## Verification
The bench walks the instruction column through both pause loops. A controller that mixes up exit2-IR and exit1-IR, or that shifts on the edge leaving exit2-IR, ends up with the wrong opcode. Select lines are checked in the middle of an instruction shift, because an instruction register updated on the rising edge would change them too early. Undecoded opcodes and forced reset by `tms` are covered, and so is the bit seen just after a rising edge in shift-DR. An output updated on the rising edge would show the next bit half a cycle early.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W   = 5;
    localparam int DR_W   = 32;
    localparam int N_EXT  = 4;
    localparam int SEL_BYP  = 0;
    localparam int SEL_ID   = 1;
    localparam int SEL_USR  = 2;
    localparam int SEL_EXT0 = 3;
    localparam int SEL_W    = SEL_EXT0 + N_EXT;

    localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00010;
    localparam logic [IR_W-1:0] OP_USER    = 5'b00011;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
    localparam logic [IR_W-1:0] OP_EXT0    = 5'b01000;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    typedef enum logic [3:0] {
        ST_EXIT2_DR   = 4'h0,
        ST_EXIT1_DR   = 4'h1,
        ST_SHIFT_DR   = 4'h2,
        ST_PAUSE_DR   = 4'h3,
        ST_SEL_IR     = 4'h4,
        ST_UPDATE_DR  = 4'h5,
        ST_CAPTURE_DR = 4'h6,
        ST_SEL_DR     = 4'h7,
        ST_EXIT2_IR   = 4'h8,
        ST_EXIT1_IR   = 4'h9,
        ST_SHIFT_IR   = 4'hA,
        ST_PAUSE_IR   = 4'hB,
        ST_IDLE       = 4'hC,
        ST_UPDATE_IR  = 4'hD,
        ST_CAPTURE_IR = 4'hE,
        ST_RESET      = 4'hF
    } tap_state_e;

    function automatic logic [SEL_W-1:0] decode_op(input logic [IR_W-1:0] op);
        logic [SEL_W-1:0] s;
        s = '0;
        if (op == OP_IDCODE)
            s[SEL_ID] = 1'b1;
        else if (op == OP_USER)
            s[SEL_USR] = 1'b1;
        else if (op[IR_W-1:2] == OP_EXT0[IR_W-1:2])
            s[SEL_EXT0 + int'(op[1:0])] = 1'b1;
        else
            s[SEL_BYP] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_q;
    tap_state_e state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RESET:      state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:       state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:     state_d = tms ? ST_SEL_IR   : ST_CAPTURE_DR;
            ST_CAPTURE_DR: state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR:   state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR:   state_d = tms ? ST_UPDATE_DR : ST_PAUSE_DR;
            ST_PAUSE_DR:   state_d = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR:   state_d = tms ? ST_UPDATE_DR : ST_SHIFT_DR;
            ST_UPDATE_DR:  state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:     state_d = tms ? ST_RESET    : ST_CAPTURE_IR;
            ST_CAPTURE_IR: state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR:   state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR:   state_d = tms ? ST_UPDATE_IR : ST_PAUSE_IR;
            ST_PAUSE_IR:   state_d = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR:   state_d = tms ? ST_UPDATE_IR : ST_SHIFT_IR;
            ST_UPDATE_IR:  state_d = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  logic             tdi,
    output logic [IR_W-1:0]  ir_sr,
    output logic [IR_W-1:0]  ir_q,
    output logic [SEL_W-1:0] sel
);

    // shift stage: rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            ir_sr <= IR_CAPTURE;
        else if (state == ST_CAPTURE_IR)
            ir_sr <= IR_CAPTURE;
        else if (state == ST_SHIFT_IR)
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // parallel stage: falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            ir_q <= OP_IDCODE;
        else if (state == ST_RESET)
            ir_q <= OP_IDCODE;
        else if (state == ST_UPDATE_IR)
            ir_q <= ir_sr;
    end

    always_comb sel = decode_op(ir_q);

endmodule

// File: rtl/tap_code_reg.sv
module tap_code_reg
    import tap_pkg::*;
#(
    parameter int          WIDTH = 32,
    parameter logic [31:0] VALUE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       active,
    input  logic       tdi,
    output logic       lsb
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            sr_q <= '0;
        else if (active && state == ST_CAPTURE_DR)
            sr_q <= VALUE[WIDTH-1:0];
        else if (active && state == ST_SHIFT_DR)
            sr_q <= {tdi, sr_q[WIDTH-1:1]};
    end

    assign lsb = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D,
    parameter logic [31:0] USER_VALUE = 32'hC0DE_5EED
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  logic [SEL_W-1:0] sel,
    input  logic             tdi,
    input  logic             ext_tdo,
    output logic             dr_lsb
);

    localparam int N_CODE = 2;
    localparam logic [31:0] CODE_VALS [N_CODE] = '{ID_VALUE, USER_VALUE};
    localparam int          CODE_SEL  [N_CODE] = '{SEL_ID, SEL_USR};

    logic              byp_q;
    logic [N_CODE-1:0] code_lsb;
    logic              ext_any;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            byp_q <= 1'b0;
        else if (state == ST_CAPTURE_DR)
            byp_q <= 1'b0;
        else if (state == ST_SHIFT_DR && sel[SEL_BYP])
            byp_q <= tdi;
    end

    for (genvar g = 0; g < N_CODE; g++) begin : g_code
        tap_code_reg #(
            .WIDTH (DR_W),
            .VALUE (CODE_VALS[g])
        ) code_i (
            .tck    (tck),
            .trst_n (trst_n),
            .state  (state),
            .active (sel[CODE_SEL[g]]),
            .tdi    (tdi),
            .lsb    (code_lsb[g])
        );
    end

    assign ext_any = |sel[SEL_EXT0 +: N_EXT];

    always_comb begin
        if (sel[SEL_ID])
            dr_lsb = code_lsb[0];
        else if (sel[SEL_USR])
            dr_lsb = code_lsb[1];
        else if (ext_any)
            dr_lsb = ext_tdo;
        else
            dr_lsb = byp_q;
    end

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D,
    parameter logic [31:0] USER_VALUE = 32'hC0DE_5EED
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic             ext_tdo,
    output logic             tdo,
    output logic             tdo_en,
    output logic [SEL_W-1:0] inst_sel,
    output logic [3:0]       tap_state
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    logic            dr_lsb;

    tap_fsm fsm_i (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir ir_i (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_sr  (ir_sr),
        .ir_q   (ir_q),
        .sel    (inst_sel)
    );

    tap_dr #(
        .ID_VALUE   (ID_VALUE),
        .USER_VALUE (USER_VALUE)
    ) dr_i (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .sel     (inst_sel),
        .tdi     (tdi),
        .ext_tdo (ext_tdo),
        .dr_lsb  (dr_lsb)
    );

    // output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            unique case (state)
                ST_SHIFT_IR: begin
                    tdo    <= ir_sr[0];
                    tdo_en <= 1'b1;
                end
                ST_SHIFT_DR: begin
                    tdo    <= dr_lsb;
                    tdo_en <= 1'b1;
                end
                default: tdo_en <= 1'b0;
            endcase
        end
    end

    assign tap_state = state;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
(
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic [3:0]       state,
    input logic [IR_W-1:0]  ir_sr,
    input logic [IR_W-1:0]  ir_q,
    input logic [SEL_W-1:0] inst_sel,
    input logic             tdo_en
);

    // R2
    reset_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    // R2
    reset_forces_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |-> (ir_q == OP_IDCODE));

    // R4
    ir_hold_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SHIFT_IR) |=> $stable(ir_q));

    // R4
    ir_latched_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPDATE_IR) |-> (ir_q == ir_sr));

    // R5
    exit1_to_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EXIT1_IR && tms) |=> (state == ST_UPDATE_IR));

    // R5
    exit2_to_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EXIT2_IR && !tms) |=> (state == ST_SHIFT_IR));

    // R11
    tdo_en_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_SHIFT_IR && state != ST_SHIFT_DR) |-> !tdo_en);

    // R12
    sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(inst_sel) == 1);

endmodule

bind tap_port tap_port_chk chk_i (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (tap_state),
    .ir_sr    (ir_sr),
    .ir_q     (ir_q),
    .inst_sel (inst_sel),
    .tdo_en   (tdo_en)
);

// File: tb/tap_port_tb_top.sv
module tap_port_tb_top;

    localparam logic [31:0] IDV   = 32'h2B7D_40C3;
    localparam logic [31:0] USRV  = 32'h6E19_F0A4;
    localparam logic [31:0] DIN   = 32'h9C3A_5E71;
    localparam logic [31:0] BYPX  = {DIN[30:0], 1'b0};
    localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [4:0]  op;
        logic [6:0]  sel;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'b00010, 7'b0000010, IDV},   // R6
        '{5'b00011, 7'b0000100, USRV},  // R7
        '{5'b11111, 7'b0000001, BYPX},  // R8
        '{5'b00000, 7'b0000001, BYPX},  // R9
        '{5'b10101, 7'b0000001, BYPX},  // R9
        '{5'b01000, 7'b0001000, ONES},  // R10
        '{5'b01001, 7'b0010000, ONES},  // R10
        '{5'b01010, 7'b0100000, ONES},  // R10
        '{5'b01011, 7'b1000000, ONES}   // R10
    };

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       ext_tdo = 1'b1;
    logic       tdo;
    logic       tdo_en;
    logic [6:0] inst_sel;
    logic [3:0] tap_state;

    int checks = 0;
    int errors = 0;

    always #10 tck = ~tck;

    tap_port #(.ID_VALUE(IDV), .USER_VALUE(USRV)) dut_i (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .ext_tdo   (ext_tdo),
        .tdo       (tdo),
        .tdo_en    (tdo_en),
        .inst_sel  (inst_sel),
        .tap_state (tap_state)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #2;
    endtask

    task automatic st(input logic m, input logic [3:0] exp, input string req);
        tick(m, 1'b0);
        check(tap_state == exp, req, 32'(tap_state), 32'(exp));
    endtask

    task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) begin
            cap[i] = tdo;
            tick(i == 4, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic shift_dr(input logic [31:0] din, output logic [31:0] dout, output logic en);
        tick(1, 0); tick(0, 0); tick(0, 0);
        en = tdo_en;
        for (int i = 0; i < 32; i++) begin
            dout[i] = tdo;
            tick(i == 31, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0]  cap;
        logic [31:0] dout;
        logic        en;

        // R1: reset state
        #35;
        check(tap_state == 4'hF, "R1 state", 32'(tap_state), 32'hF);
        check(tdo_en == 1'b0, "R1 tdo_en", 32'(tdo_en), 32'h0);
        check(inst_sel == 7'b0000010, "R1 sel", 32'(inst_sel), 32'h2);
        @(negedge tck); #2;
        trst_n = 1'b1;
        tick(0, 0);
        check(tap_state == 4'hC, "R1 idle", 32'(tap_state), 32'hC);
        check(tdo_en == 1'b0, "R11 idle en", 32'(tdo_en), 32'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            load_ir(VECS[v].op, cap);
            check(cap == 5'b00001, "R3 capture", 32'(cap), 32'h1);
            check(inst_sel == VECS[v].sel, "R9 R10 sel", 32'(inst_sel), 32'(VECS[v].sel));
            shift_dr(DIN, dout, en);
            check(dout == VECS[v].exp, "R6 R7 R8 R10 dr", dout, VECS[v].exp);
            check(en == 1'b1, "R11 shift en", 32'(en), 32'h1);
            check(tdo_en == 1'b0, "R11 after en", 32'(tdo_en), 32'h0);
        end

        // R2: tms reset forces IDCODE
        load_ir(5'b00011, cap);
        check(inst_sel == 7'b0000100, "R2 pre", 32'(inst_sel), 32'h4);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check(tap_state == 4'hF, "R2 state", 32'(tap_state), 32'hF);
        check(inst_sel == 7'b0000010, "R2 sel", 32'(inst_sel), 32'h2);
        tick(0, 0);

        // R5/R4: pause loop back to shift, opcode 00011 = b0 1, b1 1
        st(1, 4'h7, "R5 seldr");
        st(1, 4'h4, "R5 selir");
        st(0, 4'hE, "R5 capir");
        st(0, 4'hA, "R5 shir");
        tick(0, 1);
        check(inst_sel == 7'b0000010, "R4 hold mid shift", 32'(inst_sel), 32'h2);
        tick(0, 1);
        tick(1, 0);
        check(tap_state == 4'h9, "R5 ex1", 32'(tap_state), 32'h9);
        st(0, 4'hB, "R5 pause");
        st(0, 4'hB, "R5 pause hold");
        st(1, 4'h8, "R5 ex2");
        st(0, 4'hA, "R5 back shift");
        tick(0, 0);
        tick(1, 0);
        check(inst_sel == 7'b0000010, "R4 hold before update", 32'(inst_sel), 32'h2);
        st(1, 4'hD, "R5 upd");
        check(inst_sel == 7'b0000100, "R4 R5 new opcode", 32'(inst_sel), 32'h4);
        st(1, 4'h7, "R5 upd to seldr");
        st(0, 4'h6, "R5 capdr");
        st(1, 4'h1, "R5 ex1dr");
        st(1, 4'h5, "R5 upddr");
        st(0, 4'hC, "R5 idle");
        shift_dr(DIN, dout, en);
        check(dout == USRV, "R7 after pause", dout, USRV);

        // R5: exit2 straight to update, BYPASS
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(i == 4, 1);
        st(0, 4'hB, "R5 pause2");
        st(1, 4'h8, "R5 ex2b");
        st(1, 4'hD, "R5 ex2 to upd");
        st(0, 4'hC, "R5 upd to idle");
        check(inst_sel == 7'b0000001, "R5 bypass sel", 32'(inst_sel), 32'h1);

        // R11: tdo changes on falling edge (IDCODE bits 0 and 1)
        load_ir(5'b00010, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        check(tdo == IDV[0], "R11 bit0", 32'(tdo), 32'(IDV[0]));
        tms = 0;
        @(posedge tck); #2;
        check(tdo == IDV[0], "R11 held past rise", 32'(tdo), 32'(IDV[0]));
        @(negedge tck); #2;
        check(tdo == IDV[1], "R11 bit1 at fall", 32'(tdo), 32'(IDV[1]));
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R1: async reset mid-operation
        tick(1, 0);
        #3;
        trst_n = 1'b0;
        #1;
        check(tap_state == 4'hF, "R1 async", 32'(tap_state), 32'hF);
        check(inst_sel == 7'b0000010, "R1 async sel", 32'(inst_sel), 32'h2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule